// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block links two bidirectional 18-bit buses, port A and port B. There is one storage stage for each direction: A to B, and B to A. Each stage has its own latch-enable, clock, clock-enable and output-enable inputs.

The latch-enable level picks how the stage behaves:
- With latch-enable high, the stage passes its input straight through.
- With latch-enable low, the stage either holds its contents or takes a new word on a rising clock edge, depending on the clock-enable.

Each destination port is driven only while that direction's active-low output-enable is asserted. Otherwise the port is released to whatever else drives the bus.

A typical use is to sit between two bus segments. Each direction is set up on its own as a transparent buffer, a level latch, or a clocked pipeline register. The output-enables turn the bus around. An active-low asynchronous reset clears both stages to zero so that simulation starts from a known state.

Top module: `ubt_xcvr`

## Requirements
- R1: While rst_ni is low, both stored words become zero. After release, with latch-enable low and no capture, an enabled destination port shows all zeros.
- R2: While a direction's latch-enable is high, its enabled destination port follows the source port continuously, with no clock edge needed.
- R3: When latch-enable falls, the source value present at that moment is kept. It stays on the destination port while the clock is held static high or static low, whatever the source does.
- R4: With latch-enable low and clock-enable low, a rising clock edge captures the source value. It appears on the destination port and is kept until the next change of mode.
- R5: With latch-enable low and clock-enable high, rising clock edges are ignored and the stored word does not change.
- R6: With latch-enable high, a rising clock edge has no effect, whatever the clock-enable. The stage stays transparent.
- R7: The output-enable is active-low. When high, the destination port is released and an external driver's value reads back unchanged. When it goes low again, the stored word reappears.
- R8: The B-to-A direction follows R2 to R7 with its own four controls. Port B is its source and port A its destination.
- R9: The two directions are independent. Capturing or latching in one leaves the word stored in the other unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low; clears both stages |
| a_io | inout | 18 | Port A bus: source for A-to-B, destination for B-to-A |
| b_io | inout | 18 | Port B bus: source for B-to-A, destination for A-to-B |
| oe_ab_ni | input | 1 | Drive port B from the A-to-B stage, active low |
| le_ab_i | input | 1 | A-to-B latch enable: high is transparent |
| clk_ab_i | input | 1 | A-to-B capture clock, rising edge |
| clken_ab_ni | input | 1 | A-to-B clock enable, active low |
| oe_ba_ni | input | 1 | Drive port A from the B-to-A stage, active low |
| le_ba_i | input | 1 | B-to-A latch enable: high is transparent |
| clk_ba_i | input | 1 | B-to-A capture clock, rising edge |
| clken_ba_ni | input | 1 | B-to-A clock enable, active low |

## Verification
Two events can coincide in one stage:
- a rising clock edge can arrive while latch-enable is high;
- a latch-enable fall can lie between two clock edges, so that the held word comes from the latch rather than the flop.

The bench sweeps every latch-enable and clock-enable pairing for each data pattern. In each case it fires an edge and compares the destination port with the word computed from the mode: transparent gives the new source, capture gives the new source, and an ignored edge gives the old word. It then holds the clock static high and changes the source to confirm the hold. A contention check flags any cycle where the bench drives a port that the block is also driving.

// File: rtl/ubt_pkg.sv
`timescale 1ns/1ps
package ubt_pkg;
  parameter int UBT_DATA_W = 18;

  // which element feeds the stage output
  typedef enum logic [1:0] {
    SRC_LIVE  = 2'd0,
    SRC_LATCH = 2'd1,
    SRC_FLOP  = 2'd2
  } src_e;
endpackage

// File: rtl/ubt_stage.sv
`timescale 1ns/1ps
module ubt_stage
  import ubt_pkg::*;
#(
  parameter int DATA_W = UBT_DATA_W
) (
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              clk_i,
  input  logic              clken_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] lat_q;
  logic [DATA_W-1:0] flop_q;
  logic              flop_sel_q;
  src_e              src;

  // level latch: loads while transparent, keeps value present at le fall
  always_latch begin
    if (!rst_ni)   lat_q <= '0;
    else if (le_i) lat_q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flop_q <= '0;
    else if (!le_i && !clken_ni) flop_q <= d_i;
  end

  // set by a capture, cleared whenever the stage goes transparent
  always_ff @(posedge clk_i or negedge rst_ni or posedge le_i) begin
    if (!rst_ni)        flop_sel_q <= 1'b0;
    else if (le_i)      flop_sel_q <= 1'b0;
    else if (!clken_ni) flop_sel_q <= 1'b1;
  end

  always_comb begin
    if (le_i)            src = SRC_LIVE;
    else if (flop_sel_q) src = SRC_FLOP;
    else                 src = SRC_LATCH;
  end

  always_comb begin
    unique case (src)
      SRC_LIVE: q_o = d_i;
      SRC_FLOP: q_o = flop_q;
      default:  q_o = lat_q;
    endcase
  end

  // checker support: marks a transparent interval since the last edge
  logic le_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni or posedge le_i) begin
    if (!rst_ni)   le_seen_q <= 1'b0;
    else if (le_i) le_seen_q <= 1'b1;
    else           le_seen_q <= 1'b0;
  end

  AST_CLK_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !clken_ni) |=> (le_seen_q || q_o == $past(d_i))); // R4
  AST_CLKEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && clken_ni) |=> (le_seen_q || $stable(q_o)));        // R5
endmodule

// File: rtl/ubt_port_drv.sv
`timescale 1ns/1ps
module ubt_port_drv #(
  parameter int DATA_W = 18
) (
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] val_i,
  inout  wire  [DATA_W-1:0] pad_io
);
  assign pad_io = !oe_ni ? val_i : {DATA_W{1'bz}};
endmodule

// File: rtl/ubt_xcvr.sv
`timescale 1ns/1ps
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int DATA_W = UBT_DATA_W
) (
  input  logic              rst_ni,
  inout  wire  [DATA_W-1:0] a_io,
  inout  wire  [DATA_W-1:0] b_io,
  input  logic              oe_ab_ni,
  input  logic              le_ab_i,
  input  logic              clk_ab_i,
  input  logic              clken_ab_ni,
  input  logic              oe_ba_ni,
  input  logic              le_ba_i,
  input  logic              clk_ba_i,
  input  logic              clken_ba_ni
);
  localparam int NUM_DIR = 2;  // 0: A to B, 1: B to A

  logic [NUM_DIR-1:0]             le_v, clk_v, clken_v;
  logic [NUM_DIR-1:0][DATA_W-1:0] din, dq;

  assign le_v    = {le_ba_i, le_ab_i};
  assign clk_v   = {clk_ba_i, clk_ab_i};
  assign clken_v = {clken_ba_ni, clken_ab_ni};
  assign din[0]  = a_io;
  assign din[1]  = b_io;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    ubt_stage #(.DATA_W(DATA_W)) u_stage (
      .rst_ni   (rst_ni),
      .le_i     (le_v[g]),
      .clk_i    (clk_v[g]),
      .clken_ni (clken_v[g]),
      .d_i      (din[g]),
      .q_o      (dq[g])
    );
  end

  ubt_port_drv #(.DATA_W(DATA_W)) u_drv_b (
    .oe_ni  (oe_ab_ni),
    .val_i  (dq[0]),
    .pad_io (b_io)
  );

  ubt_port_drv #(.DATA_W(DATA_W)) u_drv_a (
    .oe_ni  (oe_ba_ni),
    .val_i  (dq[1]),
    .pad_io (a_io)
  );

  AST_B_SHOWS_STORE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !oe_ab_ni |-> b_io == dq[0]);                                 // R7
  AST_A_SHOWS_STORE: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !oe_ba_ni |-> a_io == dq[1]);                                 // R8
  AST_AB_PASS: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (le_ab_i && !oe_ab_ni && oe_ba_ni) |-> b_io == a_io);         // R2
  AST_BA_PASS: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (le_ba_i && !oe_ba_ni && oe_ab_ni) |-> a_io == b_io);         // R8
endmodule

// File: tb/ubt_xcvr_bench.sv
`timescale 1ns/1ps
module ubt_xcvr_bench;
  localparam int  W = 18;
  localparam time CLK_PERIOD = 10;

  logic         rst_n;
  wire  [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_drv, b_drv;
  logic         a_en, b_en;
  logic         oe_ab_n, le_ab, clk_ab, ck_ab_n;
  logic         oe_ba_n, le_ba, clk_ba, ck_ba_n;
  int           n_chk = 0, n_bad = 0;
  bit           done  = 0;

  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};

  ubt_xcvr #(.DATA_W(W)) u_ubt_xcvr (
    .rst_ni      (rst_n),
    .a_io        (a_bus),
    .b_io        (b_bus),
    .oe_ab_ni    (oe_ab_n),
    .le_ab_i     (le_ab),
    .clk_ab_i    (clk_ab),
    .clken_ab_ni (ck_ab_n),
    .oe_ba_ni    (oe_ba_n),
    .le_ba_i     (le_ba),
    .clk_ba_i    (clk_ba),
    .clken_ba_ni (ck_ba_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // dir 0: A source, B destination; dir 1: B source, A destination
  task automatic drive_src(input bit dir, input logic [W-1:0] v);
    if ((dir == 0 && !oe_ba_n) || (dir == 1 && !oe_ab_n)) begin
      n_chk++; n_bad++;
      $display("FAIL R7 contention actual=driven expected=released");
    end
    if (dir == 0) begin a_drv = v; a_en = 1'b1; end
    else          begin b_drv = v; b_en = 1'b1; end
  endtask

  function automatic logic [W-1:0] dst(input bit dir);
    return dir ? a_bus : b_bus;
  endfunction

  task automatic set_mode(input bit dir, input bit le, input bit ck_n);
    if (dir == 0) begin le_ab = le; ck_ab_n = ck_n; end
    else          begin le_ba = le; ck_ba_n = ck_n; end
  endtask

  task automatic set_clk(input bit dir, input bit v);
    if (dir == 0) clk_ab = v; else clk_ba = v;
    #(CLK_PERIOD/2);
  endtask

  // release own driver before the block drives, never the reverse
  task automatic configure(input bit dir);
    if (dir == 0) begin
      oe_ba_n = 1'b1; #1; a_en = 1'b1; b_en = 1'b0; #1; oe_ab_n = 1'b0;
    end else begin
      oe_ab_n = 1'b1; #1; b_en = 1'b1; a_en = 1'b0; #1; oe_ba_n = 1'b0;
    end
    #1;
  endtask

  task automatic run_dir(input bit dir);
    string tg;
    tg = dir ? "R8/" : "";
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] v0, v1, e1, e2;
      v0 = W'(32'h15A5A * (p + 1)) ^ W'(p << 9);
      v1 = ~v0;
      for (int lev = 0; lev < 2; lev++) begin
        for (int ck = 0; ck < 2; ck++) begin
          configure(dir);
          set_mode(dir, 1'b1, 1'b1);
          drive_src(dir, v0); #1;
          chk({tg, "R2 transparent load"}, dst(dir), v0);
          set_mode(dir, 1'b0, 1'b1); #1;
          drive_src(dir, v1); #1;
          chk({tg, "R3 hold clock low"}, dst(dir), v0);
          set_mode(dir, lev[0], ck[0]); #1;
          if (lev != 0) chk({tg, "R6 transparent before edge"}, dst(dir), v1);
          else          chk({tg, "R3 hold before edge"}, dst(dir), v0);
          set_clk(dir, 1'b1);
          e1 = (lev != 0 || ck == 0) ? v1 : v0;
          if (lev != 0)     chk({tg, "R6 edge while transparent"}, dst(dir), e1);
          else if (ck == 0) chk({tg, "R4 capture on edge"}, dst(dir), e1);
          else              chk({tg, "R5 edge ignored"}, dst(dir), e1);
          drive_src(dir, v1 ^ W'(1)); #1;
          e2 = (lev != 0) ? (v1 ^ W'(1)) : e1;
          chk({tg, "R3 hold clock high"}, dst(dir), e2);
          set_clk(dir, 1'b0);
          set_mode(dir, 1'b0, 1'b1); #1;
          drive_src(dir, v0); #1;
          chk({tg, "R3 hold after latch close"}, dst(dir), e2);
          // release destination and drive it from outside
          if (dir == 0) begin oe_ab_n = 1'b1; #1; b_drv = v0 ^ W'(3); b_en = 1'b1; end
          else          begin oe_ba_n = 1'b1; #1; a_drv = v0 ^ W'(3); a_en = 1'b1; end
          #1;
          chk({tg, "R7 released port"}, dst(dir), v0 ^ W'(3));
          if (dir == 0) begin b_en = 1'b0; #1; oe_ab_n = 1'b0; end
          else          begin a_en = 1'b0; #1; oe_ba_n = 1'b0; end
          #1;
          chk({tg, "R7 re-enabled store"}, dst(dir), e2);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x_val, y_val;
    rst_n = 1'b0;
    a_drv = W'(18'h2D2D2); b_drv = '0; a_en = 1'b1; b_en = 1'b0;
    oe_ab_n = 1'b0; oe_ba_n = 1'b1;
    le_ab = 1'b0; clk_ab = 1'b0; ck_ab_n = 1'b1;
    le_ba = 1'b0; clk_ba = 1'b0; ck_ba_n = 1'b1;
    #(CLK_PERIOD);
    rst_n = 1'b1; #1;
    chk("R1 A-to-B after reset", b_bus, '0);
    configure(1'b1);
    chk("R1 B-to-A after reset", a_bus, '0);

    run_dir(1'b0);
    run_dir(1'b1);

    // R9: a capture in B-to-A leaves the A-to-B word alone
    x_val = W'(18'h0F0F1);
    y_val = W'(18'h30C3C);
    configure(1'b0);
    set_mode(1'b0, 1'b1, 1'b1); drive_src(1'b0, x_val); #1;
    set_mode(1'b0, 1'b0, 1'b1); #1;
    configure(1'b1);
    set_mode(1'b1, 1'b0, 1'b0); drive_src(1'b1, y_val); #1;
    set_clk(1'b1, 1'b1); set_clk(1'b1, 1'b0);
    set_mode(1'b1, 1'b0, 1'b1); #1;
    chk("R8 capture for R9", a_bus, y_val);
    configure(1'b0);
    chk("R9 A-to-B word kept", b_bus, x_val);
    drive_src(1'b0, ~x_val);
    set_clk(1'b0, 1'b1); set_clk(1'b0, 1'b0);
    configure(1'b1);
    chk("R9 B-to-A word kept", a_bus, y_val);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule